// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block decides which operating mode a CAN protocol controller is in: normal run, low-power sleep, or configuration (init). Software talks to it through a single write strobe. The strobe carries three request bits: sleep, init and wake-up enable. The block answers with acknowledge bits. Each request is honoured only when the controller can safely change mode, and software cannot withdraw a request that has not yet been acknowledged.

Status inputs from the rest of the controller feed the mode changes:

- receiver busy and transmit-buffers-empty decide when the bus counts as idle for sleep entry;
- bus activity can end sleep;
- a sampled receive bit, qualified by a bit-time strobe, is used to regain bus synchronisation after init;
- the bus-off state selects a longer synchronisation wait.

The block drives these outputs:

- a force-recessive control for the transmit pin;
- a one-cycle reset strobe for the neighbouring control, flag, interrupt-enable and transmit-control registers;
- a write enable for the configuration registers;
- a one-cycle wake-up interrupt flag;
- a synchronised flag.

Top module: `can_mode_seq`

## Requirements
- R1: When `sleep_req` is 1, `rx_busy` is 0, `tx_empty` is 1 and both `init_req` and `init_ack` are 0 at a clock edge, `sleep_ack` is 1 after that edge. Under any other condition, `sleep_ack` does not rise.
- R2: A write (`wr_en`=1) with `wr_sleep_req`=0 while `sleep_req`=1 and `sleep_ack`=0 leaves `sleep_req` at 1. A write with `wr_sleep_req`=1 sets it.
- R3: A write with `wr_sleep_req`=0 while `sleep_ack`=1 clears `sleep_req` at that edge. `sleep_ack` falls at the following edge.
- R4: When `sleep_ack`=1, `wake_en`=1 and `bus_activity`=1 at an edge, both `sleep_req` and `sleep_ack` become 0 and `wake_irq` is 1 for exactly that one cycle.
- R5: When `wake_en`=0, `bus_activity` during sleep leaves `sleep_req` and `sleep_ack` at 1. Each write loads `wake_en` from `wr_wake_en`.
- R6: `tx_force_rec` is 1 in every cycle where `init_req` is 1. `init_ack` rises at the edge after `init_req` is first seen at 1.
- R7: A write with `wr_init_req`=0 while `init_req`=1 and `init_ack`=0 leaves `init_req` at 1. While `init_ack`=1, the same write clears it.
- R8: `regs_rst` is 1 for exactly the one cycle in which `init_ack` first reads 1 after being 0.
- R9: `cfg_wr_en` is 1 exactly in the cycles where `init_req` and `init_ack` are both 1.
- R10: After `init_req` is cleared, `init_ack` falls at the next edge and `synced` is 0. When `bus_off` is 0, `synced` becomes 1 after the edge that samples the 11th consecutive strobed recessive bit (`rx_bit`=1 with `bit_strobe`=1). The search also runs from reset.
- R11: A strobed dominant bit (`rx_bit`=0) restarts the current run of recessive bits. When `bus_off` is 1 as the runs complete, `synced` rises only after the 128th completed run of 11.
- R12: If `sleep_req` and `init_req` are both set from run mode, init is entered and `sleep_ack` stays 0. `tx_force_rec` is also 1 whenever `sleep_ack` or `init_ack` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| wr_en | input | 1 | Write strobe that carries the three request bits |
| wr_sleep_req | input | 1 | Requested value of the sleep request |
| wr_init_req | input | 1 | Requested value of the init request |
| wr_wake_en | input | 1 | New value of the wake-up enable |
| rx_busy | input | 1 | A frame is being received |
| tx_empty | input | 1 | All transmit buffers are empty |
| bus_off | input | 1 | Controller is in the bus-off state |
| rx_bit | input | 1 | Sampled bus bit, 1 = recessive |
| bit_strobe | input | 1 | Qualifies `rx_bit` once per bit time |
| bus_activity | input | 1 | Activity detected on the bus |
| sleep_req | output | 1 | Current sleep request |
| sleep_ack | output | 1 | Sleep mode active |
| init_req | output | 1 | Current init request |
| init_ack | output | 1 | Init mode active |
| wake_en | output | 1 | Current wake-up enable |
| tx_force_rec | output | 1 | Force the transmit pin recessive |
| regs_rst | output | 1 | One-cycle reset strobe for neighbouring registers |
| cfg_wr_en | output | 1 | Configuration registers may be written |
| wake_irq | output | 1 | One-cycle flag: sleep ended by bus activity |
| synced | output | 1 | Controller has synchronised to the bus |

## Verification
The checker watches several properties on every cycle:

- both guarded handshakes hold a pending request until it is acknowledged;
- sleep acknowledge rises only after an idle-bus cycle;
- the reset strobe and the wake flag last a single cycle;
- the transmit pin is forced whenever init is requested or sleep is active;
- `synced` rises only after a strobed recessive bit, and is low as init ends.

Some behaviour only the bench scenarios can show: the exact count of 11 bits, the restart of a run on a dominant bit, the 128-run wait while bus-off, whether `wake_en` decides if sleep survives bus activity, and the precedence of init over sleep. The bench also compares every output against a behavioural model on every clock.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  // Request bits carried by one software write
  typedef struct packed {
    logic sleep;
    logic init;
    logic wake;
  } mode_wr_t;

  // Synchronisation search state
  typedef enum logic [1:0] {
    HUNT_HOLD   = 2'd0,
    HUNT_SEARCH = 2'd1,
    HUNT_LOCKED = 2'd2
  } hunt_state_t;

endpackage

// File: rtl/can_mode_hs.sv
// Request/acknowledge handshake for sleep and init, with wake-up handling.
module can_mode_hs
  import can_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  mode_wr_t wr_data,
  input  logic     rx_busy,
  input  logic     tx_empty,
  input  logic     bus_activity,
  output logic     sleep_req,
  output logic     sleep_ack,
  output logic     init_req,
  output logic     init_ack,
  output logic     wake_en,
  output logic     regs_rst,
  output logic     wake_irq
);

  logic sleep_req_d, sleep_ack_d, init_req_d, init_ack_d, wake_en_d;
  logic regs_rst_d, wake_irq_d;
  logic bus_idle, wake_hit, sleep_entry;

  assign bus_idle    = !rx_busy && tx_empty;
  assign wake_hit    = sleep_ack && wake_en && bus_activity;
  assign sleep_entry = sleep_req && !sleep_ack && !init_req && !init_ack && bus_idle;

  always_comb begin
    // wake-up enable: plain load on write
    wake_en_d = wr_en ? wr_data.wake : wake_en;

    // sleep request: set freely, clear only once acknowledged, self-clear on wake
    sleep_req_d = sleep_req;
    if (wake_hit)
      sleep_req_d = 1'b0;
    else if (wr_en) begin
      if (wr_data.sleep)
        sleep_req_d = 1'b1;
      else if (sleep_ack)
        sleep_req_d = 1'b0;
    end

    // init request: set freely, clear only once acknowledged
    init_req_d = init_req;
    if (wr_en) begin
      if (wr_data.init)
        init_req_d = 1'b1;
      else if (init_ack)
        init_req_d = 1'b0;
    end

    // init acknowledge follows the request one edge later
    init_ack_d = init_ack;
    if (init_req && !init_ack)
      init_ack_d = 1'b1;
    else if (!init_req && init_ack)
      init_ack_d = 1'b0;
    regs_rst_d = init_req && !init_ack;

    // sleep acknowledge
    sleep_ack_d = sleep_ack;
    if (wake_hit)
      sleep_ack_d = 1'b0;
    else if (sleep_ack && !sleep_req)
      sleep_ack_d = 1'b0;
    else if (sleep_entry)
      sleep_ack_d = 1'b1;
    wake_irq_d = wake_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_req <= 1'b0;
      sleep_ack <= 1'b0;
      init_req  <= 1'b0;
      init_ack  <= 1'b0;
      wake_en   <= 1'b0;
      regs_rst  <= 1'b0;
      wake_irq  <= 1'b0;
    end else begin
      sleep_req <= sleep_req_d;
      sleep_ack <= sleep_ack_d;
      init_req  <= init_req_d;
      init_ack  <= init_ack_d;
      wake_en   <= wake_en_d;
      regs_rst  <= regs_rst_d;
      wake_irq  <= wake_irq_d;
    end
  end

endmodule

// File: rtl/can_sync_hunt.sv
// Bus synchronisation search: runs of recessive bits, counted runs when bus-off.
module can_sync_hunt
  import can_mode_pkg::*;
#(
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_req,
  input  logic init_ack,
  input  logic bit_strobe,
  input  logic rx_bit,
  input  logic bus_off,
  output logic synced
);

  localparam int RUN_W = (RUN_LEN   > 1) ? $clog2(RUN_LEN)   : 1;
  localparam int OCC_W = (RUN_COUNT > 1) ? $clog2(RUN_COUNT) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [OCC_W-1:0] OCC_LAST = OCC_W'(RUN_COUNT - 1);

  hunt_state_t      state_q, state_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic [OCC_W-1:0] occ_q, occ_d;
  logic             run_done;

  assign run_done = bit_strobe && rx_bit && (run_q == RUN_LAST);

  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    occ_d   = occ_q;
    if (init_req) begin
      state_d = HUNT_HOLD;
      run_d   = '0;
      occ_d   = '0;
    end else if (init_ack) begin
      state_d = HUNT_SEARCH;
      run_d   = '0;
      occ_d   = '0;
    end else if (state_q == HUNT_SEARCH && bit_strobe) begin
      if (!rx_bit)
        run_d = '0;
      else if (run_done) begin
        run_d = '0;
        occ_d = occ_q + 1'b1;
        if (!bus_off || occ_q == OCC_LAST)
          state_d = HUNT_LOCKED;
      end else
        run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HUNT_SEARCH;
      run_q   <= '0;
      occ_q   <= '0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
      occ_q   <= occ_d;
    end
  end

  assign synced = (state_q == HUNT_LOCKED);

endmodule

// File: rtl/can_mode_seq.sv
// Mode sequencer top: run, sleep and init for a CAN protocol controller.
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_sleep_req,
  input  logic wr_init_req,
  input  logic wr_wake_en,
  input  logic rx_busy,
  input  logic tx_empty,
  input  logic bus_off,
  input  logic rx_bit,
  input  logic bit_strobe,
  input  logic bus_activity,
  output logic sleep_req,
  output logic sleep_ack,
  output logic init_req,
  output logic init_ack,
  output logic wake_en,
  output logic tx_force_rec,
  output logic regs_rst,
  output logic cfg_wr_en,
  output logic wake_irq,
  output logic synced
);

  mode_wr_t wr_data;
  assign wr_data = '{sleep: wr_sleep_req, init: wr_init_req, wake: wr_wake_en};

  can_mode_hs u_hs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rx_busy      (rx_busy),
    .tx_empty     (tx_empty),
    .bus_activity (bus_activity),
    .sleep_req    (sleep_req),
    .sleep_ack    (sleep_ack),
    .init_req     (init_req),
    .init_ack     (init_ack),
    .wake_en      (wake_en),
    .regs_rst     (regs_rst),
    .wake_irq     (wake_irq)
  );

  can_sync_hunt #(
    .RUN_LEN   (RUN_LEN),
    .RUN_COUNT (RUN_COUNT)
  ) u_hunt (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_req   (init_req),
    .init_ack   (init_ack),
    .bit_strobe (bit_strobe),
    .rx_bit     (rx_bit),
    .bus_off    (bus_off),
    .synced     (synced)
  );

  // Recessive as soon as init is requested, and throughout init and sleep
  assign tx_force_rec = init_req || init_ack || sleep_ack;
  assign cfg_wr_en    = init_req && init_ack;

endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_busy,
  input logic tx_empty,
  input logic rx_bit,
  input logic bit_strobe,
  input logic sleep_req,
  input logic sleep_ack,
  input logic init_req,
  input logic init_ack,
  input logic tx_force_rec,
  input logic regs_rst,
  input logic wake_irq,
  input logic synced
);

  AST_SLEEP_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_ack) |-> $past(sleep_req && !rx_busy && tx_empty)); // R1
  AST_SLEEP_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !sleep_ack) |=> sleep_req); // R2
  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> (!sleep_ack && !sleep_req)); // R4
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq); // R4
  AST_INIT_FORCE_TX: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |-> tx_force_rec); // R6
  AST_INIT_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && !init_ack) |=> (init_req && init_ack)); // R7
  AST_RST_STROBE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_ack) |-> regs_rst); // R8
  AST_RST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    regs_rst |=> !regs_rst); // R8
  AST_UNSYNC_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_ack) |-> !synced); // R10
  AST_SYNC_ON_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced) |-> $past(bit_strobe && rx_bit)); // R11
  AST_SLEEP_FORCE_TX: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_ack |-> tx_force_rec); // R12

endmodule

bind can_mode_seq can_mode_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_busy      (rx_busy),
  .tx_empty     (tx_empty),
  .rx_bit       (rx_bit),
  .bit_strobe   (bit_strobe),
  .sleep_req    (sleep_req),
  .sleep_ack    (sleep_ack),
  .init_req     (init_req),
  .init_ack     (init_ack),
  .tx_force_rec (tx_force_rec),
  .regs_rst     (regs_rst),
  .wake_irq     (wake_irq),
  .synced       (synced)
);

// File: tb/can_mode_seq_test.sv
`timescale 1ns/1ps
module can_mode_seq_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_sleep_req = 0, wr_init_req = 0, wr_wake_en = 0;
  logic rx_busy = 0, tx_empty = 1, bus_off = 0, rx_bit = 1, bit_strobe = 0, bus_activity = 0;
  logic sleep_req, sleep_ack, init_req, init_ack, wake_en, tx_force_rec;
  logic regs_rst, cfg_wr_en, wake_irq, synced;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  can_mode_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sleep_req(wr_sleep_req),
    .wr_init_req(wr_init_req), .wr_wake_en(wr_wake_en), .rx_busy(rx_busy),
    .tx_empty(tx_empty), .bus_off(bus_off), .rx_bit(rx_bit), .bit_strobe(bit_strobe),
    .bus_activity(bus_activity), .sleep_req(sleep_req), .sleep_ack(sleep_ack),
    .init_req(init_req), .init_ack(init_ack), .wake_en(wake_en),
    .tx_force_rec(tx_force_rec), .regs_rst(regs_rst), .cfg_wr_en(cfg_wr_en),
    .wake_irq(wake_irq), .synced(synced)
  );

  // Behavioural reference: mode flags plus a search phase (0 hold, 1 search, 2 locked)
  bit m_sreq, m_sack, m_ireq, m_iack, m_wen, m_rst, m_wirq;
  int m_phase, m_run, m_runs;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sreq = 0; m_sack = 0; m_ireq = 0; m_iack = 0; m_wen = 0; m_rst = 0; m_wirq = 0;
      m_phase = 1; m_run = 0; m_runs = 0;
    end else begin
      bit wake, n_sreq, n_sack, n_ireq, n_iack;
      wake   = m_sack && m_wen && bus_activity;
      n_sreq = m_sreq;
      if (wake) n_sreq = 0;
      else if (wr_en && wr_sleep_req) n_sreq = 1;
      else if (wr_en && m_sack) n_sreq = 0;
      n_ireq = m_ireq;
      if (wr_en && wr_init_req) n_ireq = 1;
      else if (wr_en && m_iack) n_ireq = 0;
      n_iack = m_ireq;
      n_sack = m_sack;
      if (wake || (m_sack && !m_sreq)) n_sack = 0;
      else if (m_sreq && !m_ireq && !m_iack && !rx_busy && tx_empty) n_sack = 1;
      if (m_ireq) begin
        m_phase = 0; m_run = 0; m_runs = 0;
      end else if (m_iack) begin
        m_phase = 1; m_run = 0; m_runs = 0;
      end else if (m_phase == 1 && bit_strobe) begin
        if (!rx_bit) m_run = 0;
        else begin
          m_run++;
          if (m_run == 11) begin
            m_run = 0;
            m_runs++;
            if (!bus_off || m_runs == 128) m_phase = 2;
          end
        end
      end
      m_rst  = m_ireq && !m_iack;
      m_wirq = wake;
      m_wen  = wr_en ? wr_wake_en : m_wen;
      m_sreq = n_sreq; m_sack = n_sack; m_ireq = n_ireq; m_iack = n_iack;
    end
  end

  task automatic cmp(input logic act, input bit exp, input string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at t=%0t", what, act, exp, $time);
    end
  endtask

  // Compare every output with the model, 2 ns after each edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      cmp(sleep_ack,    m_sack,                      "R1 sleep_ack");
      cmp(sleep_req,    m_sreq,                      "R2 sleep_req");
      cmp(wake_irq,     m_wirq,                      "R4 wake_irq");
      cmp(wake_en,      m_wen,                       "R5 wake_en");
      cmp(init_ack,     m_iack,                      "R6 init_ack");
      cmp(init_req,     m_ireq,                      "R7 init_req");
      cmp(regs_rst,     m_rst,                       "R8 regs_rst");
      cmp(cfg_wr_en,    m_ireq && m_iack,            "R9 cfg_wr_en");
      cmp(synced,       m_phase == 2,                "R10 synced");
      cmp(tx_force_rec, m_ireq || m_iack || m_sack,  "R12 tx_force_rec");
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write(input bit s, input bit i, input bit w);
    wr_en = 1; wr_sleep_req = s; wr_init_req = i; wr_wake_en = w;
    step();
    wr_en = 0;
  endtask

  task automatic recessive_bits(input int n);
    bit_strobe = 1; rx_bit = 1;
    step(n);
    bit_strobe = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    step(2);
    // reset state
    cmp(init_ack, 0, "R6 reset init_ack");
    cmp(synced, 0, "R10 reset synced");
    rst_n = 1;
    step();

    // R11: a dominant bit in the middle restarts the run; R10: 11 recessive give sync
    recessive_bits(5);
    bit_strobe = 1; rx_bit = 0; step(); bit_strobe = 0; rx_bit = 1;
    recessive_bits(10);
    cmp(synced, 0, "R11 dominant restarts run");
    recessive_bits(1);
    cmp(synced, 1, "R10 sync after 11 recessive");

    // R1/R2: sleep held off while receiving; a clear before the ack is ignored
    rx_busy = 1;
    write(1, 0, 0);
    step(2);
    cmp(sleep_ack, 0, "R1 no sleep while rx busy");
    write(0, 0, 0);
    cmp(sleep_req, 1, "R2 early clear ignored");
    tx_empty = 0; rx_busy = 0; step(2);
    cmp(sleep_ack, 0, "R1 no sleep with tx pending");
    tx_empty = 1; step();
    cmp(sleep_ack, 1, "R1 sleep once idle");
    cmp(tx_force_rec, 1, "R12 tx forced in sleep");

    // R5: activity with wake-up disabled has no effect
    bus_activity = 1; step(3); bus_activity = 0;
    cmp(sleep_ack, 1, "R5 activity ignored");
    cmp(sleep_req, 1, "R5 request kept");

    // R3: software clears the request
    write(0, 0, 0);
    cmp(sleep_req, 0, "R3 request cleared");
    step();
    cmp(sleep_ack, 0, "R3 sleep left");

    // R4: wake on activity with wake-up enabled
    write(1, 0, 1);
    step(2);
    cmp(sleep_ack, 1, "R4 asleep again");
    bus_activity = 1; step(); bus_activity = 0;
    cmp(wake_irq, 1, "R4 wake flag");
    cmp(sleep_req, 0, "R4 self-clear");
    step();
    cmp(wake_irq, 0, "R4 wake flag one cycle");

    // R6/R7/R8/R9: init request, early clear ignored
    write(0, 1, 0);
    cmp(tx_force_rec, 1, "R6 tx forced at once");
    cmp(init_ack, 0, "R6 ack not yet");
    write(0, 0, 0);
    cmp(init_req, 1, "R7 early clear ignored");
    cmp(init_ack, 1, "R6 ack");
    cmp(regs_rst, 1, "R8 reset strobe");
    cmp(cfg_wr_en, 1, "R9 config window");
    step();
    cmp(regs_rst, 0, "R8 strobe one cycle");
    cmp(synced, 0, "R10 unsynced in init");

    // R10/R11: leave init while bus-off, 128 runs needed
    bus_off = 1;
    write(0, 0, 0);
    cmp(init_req, 0, "R7 clear after ack");
    cmp(cfg_wr_en, 0, "R9 window closed");
    step();
    cmp(init_ack, 0, "R10 ack drops");
    recessive_bits(127 * 11);
    cmp(synced, 0, "R11 127 runs not enough");
    recessive_bits(11);
    cmp(synced, 1, "R11 synced after 128 runs");
    bus_off = 0;

    // R12: sleep and init together, init wins
    write(1, 1, 0);
    step(3);
    cmp(init_ack, 1, "R12 init entered");
    cmp(sleep_ack, 0, "R12 sleep held off");
    write(1, 0, 0);
    step(4);
    cmp(sleep_ack, 1, "R12 sleep after init exit");
    step(2);

    finish_run();
  end

endmodule